// File: doc/BRIEF.md
# Subordinate Core Sync Agent

This block sits beside one subordinate processor and speaks for it on a shared 32-bit sync word, of which it owns a single byte. A master core writes command codes into that byte. The agent samples the byte, starts the local kernel when told to, and writes the completion code back. It never writes the byte while it is waiting for a command, so a master write is never lost.

After reset is released the agent runs a local init delay and then reports DONE. One parameter picks the variant. The data-mover variant can be woken early by LOAD, which lets it prepare its buffers, and it starts the kernel only once GO arrives. The compute variants wake only on GO. After the kernel returns, a compute variant waits for the processing pipeline to drain before it reports DONE. The compute-core-0 variant also serves a counter-clear command. It sweeps a bank of per-buffer counters, one buffer per cycle, then reports DONE without starting a kernel.

Top module: `sync_agent`

## Requirements
- R1: While reset is held, sync_we, kern_start and clr_en are all low.
- R2: After reset is released, the agent writes 0x00 (DONE) to its byte with a single-cycle sync_we. The mover variant asserts it after the first clock edge. Compute variants assert it after INIT_WAIT edges.
- R3: While waiting for a command the agent never asserts sync_we. Codes it does not serve leave its byte unchanged and start nothing. These are 0x00, 0x02, 0x40 for every variant, 0x01 for compute variants, and 0x03 for all but compute-core-0.
- R4: When GO (0x80) is in the byte at a sampling edge, kern_start pulses high for exactly one cycle, in the cycle after that edge.
- R5: The mover variant treats LOAD (0x01) as a wake-up. It then holds off kern_start until it samples GO, and starts the kernel one cycle after that.
- R6: kern_done is honoured only after a kern_start. In the mover variant, DONE is written in the cycle after the edge that samples kern_done. A kern_done seen while idle is ignored.
- R7: Compute variants write DONE only after pipe_idle is sampled high following kern_done. The write comes in the cycle after the edge that samples pipe_idle high.
- R8: The compute-core-0 variant treats code 0x03 as a clear command. It raises clr_en for NUM_BUF consecutive cycles with clr_idx stepping 0, 1, … NUM_BUF-1. In the next cycle it writes DONE, and it never asserts kern_start for that command.
- R9: At most one of sync_we, kern_start and clr_en is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_rd | input | 8 | Current value of the agent's byte in the sync word |
| sync_we | output | 1 | Write strobe for the agent's byte |
| sync_wd | output | 8 | Value to write (always the DONE code) |
| kern_start | output | 1 | One-cycle kernel start pulse |
| kern_done | input | 1 | Kernel finished pulse |
| pipe_idle | input | 1 | Processing pipeline drained (compute variants) |
| clr_en | output | 1 | Counter-clear strobe for buffer clr_idx |
| clr_idx | output | IDX_W | Buffer whose received and acknowledged counters are cleared |

## Verification
The bench runs three agents side by side, one per variant, so one code can be checked against the variant that serves it and the ones that must ignore it. If a design wrote back too early after a kernel, the byte would still read GO and the agent would start the kernel a second time; the bench catches this through a second kern_start or a missing DONE. A mover that started on LOAD, or a compute core that skipped the drain wait, would show kern_start or sync_we one or more cycles early. A clear sweep of the wrong length or order shows up in the per-cycle clr_idx sequence and in when DONE lands. The init delay is counted exactly from reset release for both init lengths.

// File: rtl/sync_agent_pkg.sv
package sync_agent_pkg;

    typedef enum logic [1:0] {
        VAR_MOVER    = 2'd0,
        VAR_COMPUTE  = 2'd1,
        VAR_COMPUTE0 = 2'd2
    } variant_e;

    localparam logic [7:0] CODE_DONE  = 8'h00;
    localparam logic [7:0] CODE_LOAD  = 8'h01;
    localparam logic [7:0] CODE_PARK  = 8'h02;
    localparam logic [7:0] CODE_CLEAR = 8'h03;
    localparam logic [7:0] CODE_INIT  = 8'h40;
    localparam logic [7:0] CODE_GO    = 8'h80;

    typedef enum logic [2:0] {
        S_INIT,
        S_REPORT,
        S_POLL,
        S_ARMED,
        S_LAUNCH,
        S_WAITK,
        S_DRAIN,
        S_CLEAR
    } agent_state_e;

endpackage

// File: rtl/sync_cmd_decode.sv
module sync_cmd_decode
    import sync_agent_pkg::*;
#(
    parameter variant_e VARIANT = VAR_COMPUTE0
) (
    input  logic [7:0] cmd,
    output logic       is_go,
    output logic       is_load,
    output logic       is_clear
);
    generate
        if (VARIANT == VAR_MOVER) begin : g_mover
            assign is_load  = (cmd == CODE_LOAD);
            assign is_clear = 1'b0;
        end else if (VARIANT == VAR_COMPUTE0) begin : g_core0
            assign is_load  = 1'b0;
            assign is_clear = (cmd == CODE_CLEAR);
        end else begin : g_compute
            assign is_load  = 1'b0;
            assign is_clear = 1'b0;
        end
    endgenerate

    assign is_go = (cmd == CODE_GO);
endmodule

// File: rtl/sync_tick_cnt.sv
module sync_tick_cnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/sync_agent.sv
module sync_agent
    import sync_agent_pkg::*;
#(
    parameter variant_e VARIANT   = VAR_COMPUTE0,
    parameter int       NUM_BUF   = 8,
    parameter int       INIT_WAIT = 600,
    localparam int      IDX_W     = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       sync_rd,
    output logic             sync_we,
    output logic [7:0]       sync_wd,
    output logic             kern_start,
    input  logic             kern_done,
    input  logic             pipe_idle,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx
);
    localparam bit IS_COMPUTE = (VARIANT != VAR_MOVER);
    localparam int LIMIT      = IS_COMPUTE ? INIT_WAIT : 1;
    localparam int CNT_MAX    = (LIMIT > NUM_BUF) ? LIMIT : NUM_BUF;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(LIMIT - 1);
    localparam logic [CNT_W-1:0] CLR_LAST  = CNT_W'(NUM_BUF - 1);

    typedef struct packed {
        agent_state_e st;
    } fsm_t;

    fsm_t             r_d, r_q;
    logic             go_hit, load_hit, clear_hit;
    logic             cnt_clr, cnt_inc;
    logic [CNT_W-1:0] cnt;

    sync_cmd_decode #(.VARIANT(VARIANT)) u_dec (
        .cmd      (sync_rd),
        .is_go    (go_hit),
        .is_load  (load_hit),
        .is_clear (clear_hit)
    );

    sync_tick_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    always_comb begin
        r_d     = r_q;
        cnt_inc = 1'b0;
        cnt_clr = 1'b1;
        unique case (r_q.st)
            S_INIT: begin
                if (cnt == INIT_LAST) begin
                    r_d.st = S_REPORT;
                end else begin
                    cnt_inc = 1'b1;
                    cnt_clr = 1'b0;
                end
            end
            S_REPORT: r_d.st = S_POLL;
            S_POLL: begin
                if (go_hit)         r_d.st = S_LAUNCH;
                else if (load_hit)  r_d.st = S_ARMED;
                else if (clear_hit) r_d.st = S_CLEAR;
            end
            S_ARMED: begin
                if (go_hit) r_d.st = S_LAUNCH;
            end
            S_LAUNCH: r_d.st = S_WAITK;
            S_WAITK: begin
                if (kern_done) r_d.st = IS_COMPUTE ? S_DRAIN : S_REPORT;
            end
            S_DRAIN: begin
                if (pipe_idle) r_d.st = S_REPORT;
            end
            S_CLEAR: begin
                if (cnt == CLR_LAST) begin
                    r_d.st = S_REPORT;
                end else begin
                    cnt_inc = 1'b1;
                    cnt_clr = 1'b0;
                end
            end
            default: r_d.st = S_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q.st <= S_INIT;
        else        r_q    <= r_d;
    end

    assign sync_we    = (r_q.st == S_REPORT);
    assign sync_wd    = CODE_DONE;
    assign kern_start = (r_q.st == S_LAUNCH);
    assign clr_en     = (r_q.st == S_CLEAR);
    assign clr_idx    = cnt[IDX_W-1:0];
endmodule

// File: rtl/sync_agent_chk.sv
module sync_agent_chk
    import sync_agent_pkg::*;
#(
    parameter variant_e VARIANT = VAR_COMPUTE0,
    parameter int       IDX_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       sync_rd,
    input logic             sync_we,
    input logic             kern_start,
    input logic             clr_en,
    input logic [IDX_W-1:0] clr_idx
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!sync_we && !kern_start && !clr_en));

    // R9
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sync_we, kern_start, clr_en}));

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kern_start |=> !kern_start);

    // R4
    start_on_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(kern_start) |-> $past(sync_rd) == CODE_GO);

    // R2
    write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_we |=> !sync_we);

    // R8
    clear_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_en) |-> ($past(sync_rd) == CODE_CLEAR && VARIANT == VAR_COMPUTE0 && clr_idx == '0));

    // R8
    clear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && $past(clr_en)) |-> clr_idx == IDX_W'($past(clr_idx) + 1'b1));
endmodule

bind sync_agent sync_agent_chk #(.VARIANT(VARIANT), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_rd    (sync_rd),
    .sync_we    (sync_we),
    .kern_start (kern_start),
    .clr_en     (clr_en),
    .clr_idx    (clr_idx)
);

// File: tb/tb_sync_agent.sv
`timescale 1ns/1ps
module tb_sync_agent;
    import sync_agent_pkg::*;

    localparam int NB    = 8;
    localparam int IW    = 3;
    localparam int IWAIT = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // index 0: compute core 0, 1: data mover, 2: plain compute
    logic [7:0]    byte_m [3];
    logic          s_we   [3];
    logic [7:0]    s_wd   [3];
    logic          k_st   [3];
    logic          k_dn   [3];
    logic          p_idle [3];
    logic          c_en   [3];
    logic [IW-1:0] c_idx  [3];
    logic          m_we   [3];
    logic [7:0]    m_wd   [3];

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    sync_agent #(.VARIANT(VAR_COMPUTE0), .NUM_BUF(NB), .INIT_WAIT(IWAIT)) dut (
        .clk(clk), .rst_n(rst_n), .sync_rd(byte_m[0]), .sync_we(s_we[0]), .sync_wd(s_wd[0]),
        .kern_start(k_st[0]), .kern_done(k_dn[0]), .pipe_idle(p_idle[0]),
        .clr_en(c_en[0]), .clr_idx(c_idx[0]));
    sync_agent #(.VARIANT(VAR_MOVER), .NUM_BUF(NB), .INIT_WAIT(IWAIT)) dut_dm (
        .clk(clk), .rst_n(rst_n), .sync_rd(byte_m[1]), .sync_we(s_we[1]), .sync_wd(s_wd[1]),
        .kern_start(k_st[1]), .kern_done(k_dn[1]), .pipe_idle(p_idle[1]),
        .clr_en(c_en[1]), .clr_idx(c_idx[1]));
    sync_agent #(.VARIANT(VAR_COMPUTE), .NUM_BUF(NB), .INIT_WAIT(IWAIT)) dut_cp (
        .clk(clk), .rst_n(rst_n), .sync_rd(byte_m[2]), .sync_we(s_we[2]), .sync_wd(s_wd[2]),
        .kern_start(k_st[2]), .kern_done(k_dn[2]), .pipe_idle(p_idle[2]),
        .clr_en(c_en[2]), .clr_idx(c_idx[2]));

    // shared sync byte model: master write wins over agent write
    always @(posedge clk) begin
        for (int v = 0; v < 3; v++) begin
            if (m_we[v])      byte_m[v] <= m_wd[v];
            else if (s_we[v]) byte_m[v] <= s_wd[v];
        end
    end

    // {agent, code, expect start, expect clear}
    localparam int NV = 12;
    localparam logic [11:0] VEC [NV] = '{
        {2'd0, 8'h80, 1'b1, 1'b0},  // R4 core0 GO
        {2'd0, 8'h03, 1'b0, 1'b1},  // R8 core0 clear
        {2'd0, 8'h01, 1'b0, 1'b0},  // R3 LOAD ignored by compute
        {2'd0, 8'h40, 1'b0, 1'b0},  // R3 INIT ignored
        {2'd1, 8'h80, 1'b1, 1'b0},  // R4 mover GO
        {2'd1, 8'h03, 1'b0, 1'b0},  // R3 clear ignored by mover
        {2'd1, 8'h02, 1'b0, 1'b0},  // R3 park code ignored
        {2'd1, 8'h01, 1'b0, 1'b0},  // R5 LOAD arms, no start
        {2'd1, 8'h80, 1'b1, 1'b0},  // R5 GO after LOAD
        {2'd2, 8'h03, 1'b0, 1'b0},  // R3 clear ignored by plain compute
        {2'd2, 8'h80, 1'b1, 1'b0},  // R4 plain compute GO
        {2'd0, 8'h00, 1'b0, 1'b0}   // R3 DONE code ignored
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mwrite(input int v, input logic [7:0] val);
        m_we[v] = 1'b1;
        m_wd[v] = val;
        @(negedge clk);
        m_we[v] = 1'b0;
    endtask

    task automatic pulse_done(input int v);
        k_dn[v] = 1'b1;
        @(negedge clk);
        k_dn[v] = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int first [3];
        int seen;
        for (int v = 0; v < 3; v++) begin
            byte_m[v] = CODE_INIT;
            k_dn[v]   = 1'b0;
            p_idle[v] = 1'b1;
            m_we[v]   = 1'b0;
            m_wd[v]   = 8'h00;
            first[v]  = 0;
        end

        // R1 reset state
        repeat (4) @(negedge clk);
        for (int v = 0; v < 3; v++)
            chk(!s_we[v] && !k_st[v] && !c_en[v], "R1 reset quiet",
                {s_we[v], k_st[v], c_en[v]}, 0);

        // R2 init length from reset release
        rst_n = 1'b1;
        for (int n = 1; n <= IWAIT + 20; n++) begin
            @(negedge clk);
            for (int v = 0; v < 3; v++)
                if (s_we[v] && first[v] == 0) first[v] = n;
        end
        chk(first[1] == 1, "R2 mover init", first[1], 1);
        chk(first[0] == IWAIT, "R2 core0 init", first[0], IWAIT);
        chk(first[2] == IWAIT, "R2 compute init", first[2], IWAIT);
        for (int v = 0; v < 3; v++)
            chk(byte_m[v] == CODE_DONE, "R2 DONE written", byte_m[v], 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            int v;
            logic [7:0] code;
            bit es, ec;
            v    = int'(VEC[i][11:10]);
            code = VEC[i][9:2];
            es   = VEC[i][1];
            ec   = VEC[i][0];
            mwrite(v, code);
            @(negedge clk);
            chk(k_st[v] == es, "R4/R5 start on code", k_st[v], es);
            chk(c_en[v] == ec, "R8 clear on code", c_en[v], ec);
            if (es) begin
                @(negedge clk);
                chk(!k_st[v], "R4 single start pulse", k_st[v], 0);
                seen = 0;
                repeat (3) begin
                    @(negedge clk);
                    if (s_we[v]) seen++;
                end
                chk(seen == 0, "R3 no write while kernel runs", seen, 0);
                pulse_done(v);
                seen = 0;
                repeat (4) begin
                    if (s_we[v]) seen++;
                    if (k_st[v]) seen += 10;
                    @(negedge clk);
                end
                chk(seen == 1, "R6 one DONE write, no restart", seen, 1);
                chk(byte_m[v] == CODE_DONE, "R6 byte DONE", byte_m[v], 0);
            end else if (ec) begin
                for (int b = 0; b < NB; b++) begin
                    chk(c_en[v] && c_idx[v] == IW'(b), "R8 clear sweep", {c_en[v], c_idx[v]}, {1'b1, IW'(b)});
                    @(negedge clk);
                end
                chk(s_we[v] && !k_st[v], "R8 DONE after sweep", {s_we[v], k_st[v]}, 2);
                @(negedge clk);
                chk(byte_m[v] == CODE_DONE && !c_en[v], "R8 byte DONE", byte_m[v], 0);
            end else begin
                seen = 0;
                repeat (6) begin
                    @(negedge clk);
                    if (s_we[v] || k_st[v] || c_en[v]) seen++;
                end
                chk(seen == 0, "R3 code ignored", seen, 0);
                chk(byte_m[v] == code, "R3 byte untouched", byte_m[v], code);
            end
        end

        // R7 drain wait on plain compute
        p_idle[2] = 1'b0;
        mwrite(2, CODE_GO);
        @(negedge clk);
        chk(k_st[2], "R7 started", k_st[2], 1);
        @(negedge clk);
        pulse_done(2);
        seen = 0;
        repeat (6) begin
            if (s_we[2]) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R7 held until drained", seen, 0);
        p_idle[2] = 1'b1;
        @(negedge clk);
        chk(s_we[2], "R7 DONE after drain", s_we[2], 1);
        @(negedge clk);
        chk(byte_m[2] == CODE_DONE, "R7 byte DONE", byte_m[2], 0);

        // R6 mover DONE exactly one cycle after kern_done edge
        mwrite(1, CODE_GO);
        @(negedge clk);
        @(negedge clk);
        pulse_done(1);
        chk(s_we[1], "R6 mover DONE timing", s_we[1], 1);
        @(negedge clk);

        // R6 kern_done while idle ignored
        pulse_done(1);
        seen = 0;
        repeat (4) begin
            if (s_we[1] || k_st[1]) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R6 stray done ignored", seen, 0);

        // R5 mover stays armed after LOAD for a long time
        mwrite(1, CODE_LOAD);
        seen = 0;
        repeat (20) begin
            @(negedge clk);
            if (k_st[1] || s_we[1]) seen++;
        end
        chk(seen == 0, "R5 armed without GO", seen, 0);
        mwrite(1, CODE_GO);
        @(negedge clk);
        chk(k_st[1], "R5 start after GO", k_st[1], 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule